// File: doc/BRIEF.md
# Set-Associative Cache Controller with Selectable Write Policy

This block sits between a word-addressed host port and a slower word-wide main memory. It keeps a small set-associative store of memory blocks, each of `WORDS` consecutive words, with a tag, a valid flag and a modified flag per line. A host read is looked up by comparing the tags of every way in the addressed set in the same cycle. A read hit is answered at once. A read miss brings the whole block into a line, one word per memory beat, and then answers.

Host writes follow the policy on the static `cfg_policy` input. In write-back mode (1) the cache alone is updated and the line is marked modified. In write-through mode (0, and the unused code 3) a write goes to memory as well and is answered only when memory takes it. In write-around mode (2) the write goes to memory only and never allocates. A modified victim is always copied back to memory before its line is reused. The victim way comes from a separate replacement unit: it picks the lowest invalid way, and when every way is valid it uses a per-set round-robin pointer that moves past each newly filled way. Hit and miss counters are exposed so the hit ratio can be checked.

The address splits into word offset (low `log2(WORDS)` bits), set index (next `log2(SETS)` bits) and tag (remaining high bits). Memory block transfers start at word 0 of the block and go upward.

Top module: `wpc_cache`

## Requirements
- R1: A read that hits is acknowledged in the cycle it is presented and returns the newest value of the word; `hit_count` rises by one.
- R2: A read miss on a line that needs no copy-back issues exactly `WORDS` read beats in ascending order from word 0 of the block, then acknowledges with the requested word. With memory always ready, the acknowledge comes 5 cycles after the request is presented (`WORDS`=4). `miss_count` rises by one.
- R3: In write-through mode (`cfg_policy`=0) a write is acknowledged in the cycle memory accepts its single write beat. A hit also updates the cached word, so a later read hits and returns the new value. A miss allocates nothing, so a later read of that address misses.
- R4: In write-back mode (`cfg_policy`=1) a write hit is acknowledged in the cycle it is presented, with no memory beat, and leaves memory unchanged. A write miss fills the block as for a read, writes the word into the line and acknowledges; memory stays unchanged.
- R5: When the chosen victim is valid and modified, its `WORDS` words go to memory as ascending write beats to its old block address before the fill of the new block begins. A read miss of this kind acknowledges 9 cycles after the request when memory is always ready.
- R6: In write-around mode (`cfg_policy`=2) a write goes only to memory and allocates nothing. A hit invalidates the line, so a later read misses. If that line is modified, it is first copied back as in R5, and the write then completes one cycle later (acknowledge after 5 cycles).
- R7: The synchronous active-low reset clears every valid and modified flag and both counters, so the first read after reset misses.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R9: `req_ack` is raised only while `req_valid` is high, and every held request is acknowledged.
- R10: Across any mix of policies and memory stalls, every read returns the value of the most recent host write to that address, or the initial memory value if none.
- R11: Each acknowledged request changes exactly one of `hit_count` or `miss_count`, by one.
- R12: `WAYS` blocks that map to the same set are resident together. A fill uses an invalid way if one exists, otherwise the round-robin way, so with two ways the older fill is replaced first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_policy | input | 2 | Write policy: 0 through, 1 back, 2 around, 3 as through |
| req_valid | input | 1 | Host request present; held until acknowledged |
| req_write | input | 1 | Host request is a write |
| req_addr | input | ADDR_W | Host word address |
| req_wdata | input | DATA_W | Host write data |
| req_ack | output | 1 | One-cycle acknowledge of the held request |
| req_rdata | output | DATA_W | Read data, valid with `req_ack` on reads |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts or returns the beat this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| hit_count | output | CNT_W | Lookups that hit |
| miss_count | output | CNT_W | Lookups that missed |

## Verification
The bench uses the defaults: a 10-bit address, 16-bit words, two ways, four sets and four-word blocks. With only two ways, a third block in one set forces a replacement after three reads. That makes the copy-back of a modified victim, the invalid-way preference and the round-robin order reachable in short directed sequences with exact beat logs and cycle counts. Four sets and a narrow tag range in the random phase keep both hits and conflict evictions frequent under changing policies and stalled memory.

// File: rtl/wpc_pkg.sv
// Shared types for the write-policy cache controller.
// Assumes: all users import this package before use.
package wpc_pkg;

    typedef enum logic [1:0] {
        POL_THROUGH = 2'd0,
        POL_BACK    = 2'd1,
        POL_AROUND  = 2'd2
    } policy_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVICT = 3'd1,
        ST_FILL  = 3'd2,
        ST_DONE  = 3'd3,
        ST_MEMW  = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        TAG_NOP   = 2'd0,
        TAG_FILL  = 2'd1,
        TAG_DIRTY = 2'd2,
        TAG_INVAL = 2'd3
    } tag_op_e;

endpackage

// File: rtl/wpc_tag_store.sv
// Tag, valid and modified storage with a parallel tag compare per way.
// Assumes: SETS and WAYS are powers of two, WAYS >= 2, SETS >= 2.
// One update per cycle, selected by upd_op, on the way given by upd_way.
module wpc_tag_store
    import wpc_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int SETS  = 4,
    parameter int WAYS  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(SETS)-1:0]     lk_set,
    input  logic [TAG_W-1:0]            lk_tag,
    input  tag_op_e                     upd_op,
    input  logic [$clog2(WAYS)-1:0]     upd_way,
    output logic [WAYS-1:0]             hit_vec,
    output logic [WAYS-1:0]             valid_vec,
    output logic [WAYS-1:0]             dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0]  set_tags
);

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];

    // Tag field: written when a fill completes, needs no reset.
    always_ff @(posedge clk) begin
        if (upd_op == TAG_FILL) begin
            tag_q[lk_set][upd_way] <= lk_tag;
        end
    end

    // Valid and modified flags: cleared by reset, changed by fill, write and invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            case (upd_op)
                TAG_FILL: begin
                    valid_q[lk_set][upd_way] <= 1'b1;
                    dirty_q[lk_set][upd_way] <= 1'b0;
                end
                TAG_DIRTY: dirty_q[lk_set][upd_way] <= 1'b1;
                TAG_INVAL: begin
                    valid_q[lk_set][upd_way] <= 1'b0;
                    dirty_q[lk_set][upd_way] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign valid_vec = valid_q[lk_set];
    assign dirty_vec = dirty_q[lk_set];

    // One comparator per way, all working on the addressed set at once.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_tags[w] = tag_q[lk_set][w];
        assign hit_vec[w]  = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

endmodule

// File: rtl/wpc_data_store.sv
// Word storage for all lines, one write port and one combinational read port.
// Assumes: SETS, WAYS and WORDS are powers of two.
module wpc_data_store #(
    parameter int DATA_W = 16,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int WORDS  = 4
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(SETS)-1:0]  set_sel,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic [$clog2(WORDS)-1:0] wr_word,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(WAYS)-1:0]  rd_way,
    input  logic [$clog2(WORDS)-1:0] rd_word,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int DEPTH = SETS * WAYS * WORDS;

    logic [DATA_W-1:0] word_q [DEPTH];

    // Store one word per cycle at {set, way, word}.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{set_sel, wr_way, wr_word}] <= wr_data;
        end
    end

    assign rd_data = word_q[{set_sel, rd_way, rd_word}];

endmodule

// File: rtl/wpc_victim_rr.sv
// Replacement unit: lowest invalid way first, otherwise a per-set round-robin pointer.
// Assumes: WAYS is a power of two so the pointer wraps by width.
module wpc_victim_rr #(
    parameter int SETS = 4,
    parameter int WAYS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] q_set,
    input  logic [WAYS-1:0]         valid_vec,
    input  logic                    adv_en,
    input  logic [$clog2(WAYS)-1:0] adv_way,
    output logic [$clog2(WAYS)-1:0] victim
);

    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] ptr_q [SETS];

    // Pointer moves to the way after the one just filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
            end
        end else if (adv_en) begin
            ptr_q[q_set] <= adv_way + WAY_W'(1);
        end
    end

    // Choose the lowest invalid way, else the round-robin way.
    always_comb begin
        victim = ptr_q[q_set];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                victim = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/wpc_cache.sv
// Set-associative cache controller with write-through, write-back and write-around.
// Assumes: the host holds a request stable until req_ack; cfg_policy changes only
// while no request is pending; WORDS, SETS, WAYS are powers of two, each >= 2.
module wpc_cache
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int WAYS   = 2,
    parameter int SETS   = 4,
    parameter int WORDS  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_policy,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int OFF_W = $clog2(WORDS);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    state_e            state, state_d, after_q, after_d;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_write;
    logic [WAY_W-1:0]  way_q, way_d;
    logic [TAG_W-1:0]  vtag_q, vtag_d;
    logic [OFF_W-1:0]  beat_q, beat_d;
    logic [CNT_W-1:0]  hit_q, miss_q;

    logic [ADDR_W-1:0] lk_addr;
    logic [OFF_W-1:0]  lk_off;
    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;

    logic [WAYS-1:0]             hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic                        hit_any;
    logic [WAY_W-1:0]            hit_way, victim;

    tag_op_e           t_op;
    logic [WAY_W-1:0]  t_way;
    logic              d_we;
    logic [WAY_W-1:0]  d_way, rd_way;
    logic [OFF_W-1:0]  d_word, rd_word;
    logic [DATA_W-1:0] d_wdata, rd_data;
    logic              cap, hit_inc, miss_inc, adv;
    logic              is_back, is_around;
    logic              evict_busy;

    // Address fields of the request being looked up or served.
    assign lk_addr = (state == ST_IDLE) ? req_addr : cur_addr;
    assign lk_off  = lk_addr[OFF_W-1:0];
    assign lk_set  = lk_addr[OFF_W +: SET_W];
    assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];

    assign is_back   = (cfg_policy == POL_BACK);
    assign is_around = (cfg_policy == POL_AROUND);
    assign hit_any   = |hit_vec;
    assign evict_busy = (state == ST_EVICT);

    // Encode the one-hot hit vector into a way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    wpc_tag_store #(
        .TAG_W (TAG_W),
        .SETS  (SETS),
        .WAYS  (WAYS)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (lk_set),
        .lk_tag    (lk_tag),
        .upd_op    (t_op),
        .upd_way   (t_way),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .set_tags  (set_tags)
    );

    wpc_data_store #(
        .DATA_W (DATA_W),
        .SETS   (SETS),
        .WAYS   (WAYS),
        .WORDS  (WORDS)
    ) u_data (
        .clk     (clk),
        .wr_en   (d_we),
        .set_sel (lk_set),
        .wr_way  (d_way),
        .wr_word (d_word),
        .wr_data (d_wdata),
        .rd_way  (rd_way),
        .rd_word (rd_word),
        .rd_data (rd_data)
    );

    wpc_victim_rr #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_set     (lk_set),
        .valid_vec (valid_vec),
        .adv_en    (adv),
        .adv_way   (way_q),
        .victim    (victim)
    );

    // Sequencer: lookup, copy-back, fill, finish and memory write decisions.
    always_comb begin
        state_d   = state;
        after_d   = after_q;
        way_d     = way_q;
        vtag_d    = vtag_q;
        beat_d    = beat_q;
        req_ack   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        d_we      = 1'b0;
        d_way     = way_q;
        d_word    = beat_q;
        d_wdata   = mem_rdata;
        t_op      = TAG_NOP;
        t_way     = way_q;
        rd_way    = way_q;
        rd_word   = lk_off;
        cap       = 1'b0;
        hit_inc   = 1'b0;
        miss_inc  = 1'b0;
        adv       = 1'b0;
        case (state)
            ST_IDLE: begin
                rd_way = hit_way;
                if (req_valid) begin
                    cap = 1'b1;
                    if (hit_any && (!req_write || is_back)) begin
                        // Read hit, or write-back write hit: answer now.
                        req_ack = 1'b1;
                        hit_inc = 1'b1;
                        if (req_write) begin
                            d_we    = 1'b1;
                            d_way   = hit_way;
                            d_word  = lk_off;
                            d_wdata = req_wdata;
                            t_op    = TAG_DIRTY;
                            t_way   = hit_way;
                        end
                    end else if (!req_write || is_back) begin
                        // Allocating miss: copy back a modified victim, then fill.
                        miss_inc = 1'b1;
                        way_d    = victim;
                        vtag_d   = set_tags[victim];
                        beat_d   = '0;
                        after_d  = ST_FILL;
                        state_d  = (valid_vec[victim] && dirty_vec[victim]) ? ST_EVICT : ST_FILL;
                    end else if (is_around) begin
                        // Write-around: memory only, drop any cached copy.
                        state_d = ST_MEMW;
                        if (hit_any) begin
                            hit_inc = 1'b1;
                            way_d   = hit_way;
                            vtag_d  = lk_tag;
                            beat_d  = '0;
                            after_d = ST_MEMW;
                            if (dirty_vec[hit_way]) begin
                                state_d = ST_EVICT;
                            end else begin
                                t_op  = TAG_INVAL;
                                t_way = hit_way;
                            end
                        end else begin
                            miss_inc = 1'b1;
                        end
                    end else begin
                        // Write-through: update a cached copy, then memory.
                        state_d = ST_MEMW;
                        if (hit_any) begin
                            hit_inc = 1'b1;
                            d_we    = 1'b1;
                            d_way   = hit_way;
                            d_word  = lk_off;
                            d_wdata = req_wdata;
                        end else begin
                            miss_inc = 1'b1;
                        end
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vtag_q, lk_set, beat_q};
                rd_word   = beat_q;
                mem_wdata = rd_data;
                if (mem_ready) begin
                    beat_d = beat_q + OFF_W'(1);
                    if (beat_q == LAST_BEAT) begin
                        state_d = after_q;
                        if (after_q == ST_MEMW) begin
                            t_op = TAG_INVAL;
                        end
                    end
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {lk_tag, lk_set, beat_q};
                if (mem_ready) begin
                    d_we   = 1'b1;
                    d_word = beat_q;
                    beat_d = beat_q + OFF_W'(1);
                    if (beat_q == LAST_BEAT) begin
                        t_op    = TAG_FILL;
                        adv     = 1'b1;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                req_ack = 1'b1;
                if (cur_write) begin
                    d_we    = 1'b1;
                    d_word  = lk_off;
                    d_wdata = cur_wdata;
                    t_op    = TAG_DIRTY;
                end
                state_d = ST_IDLE;
            end
            ST_MEMW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_addr;
                mem_wdata = cur_wdata;
                if (mem_ready) begin
                    req_ack = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_rdata = rd_data;

    // Sequencer registers and the captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_q   <= ST_FILL;
            way_q     <= '0;
            vtag_q    <= '0;
            beat_q    <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
        end else begin
            state   <= state_d;
            after_q <= after_d;
            way_q   <= way_d;
            vtag_q  <= vtag_d;
            beat_q  <= beat_d;
            if (cap) begin
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                cur_write <= req_write;
            end
        end
    end

    // Lookup outcome counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= '0;
            miss_q <= '0;
        end else begin
            if (hit_inc)  hit_q  <= hit_q + CNT_W'(1);
            if (miss_inc) miss_q <= miss_q + CNT_W'(1);
        end
    end

    assign hit_count  = hit_q;
    assign miss_count = miss_q;

endmodule

// File: rtl/wpc_cache_chk.sv
// Protocol and ordering checks for wpc_cache, attached by bind.
// Assumes: cfg_policy is static while requests are pending.
module wpc_cache_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int WORDS  = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_policy,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ack,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count,
    input logic              evict_busy
);

    localparam int OFF_W = $clog2(WORDS);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> req_valid); // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8

    AST_FILL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we && (mem_addr[OFF_W-1:0] != LAST_BEAT))
        |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(1)))); // R2

    AST_EVICT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_busy && mem_ready && (mem_addr[OFF_W-1:0] != LAST_BEAT))
        |=> (evict_busy && mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(1)))); // R5

    AST_BACK_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && req_write && (cfg_policy == 2'd1)) |-> !mem_req); // R4

    AST_THRU_ACK_AT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && req_write && (cfg_policy != 2'd1)) |-> (mem_req && mem_we && mem_ready)); // R3

    AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(hit_count) || $stable(miss_count))); // R11

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> ((hit_count == '0) && (miss_count == '0))); // R7

endmodule

bind wpc_cache wpc_cache_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_policy (cfg_policy),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ack    (req_ack),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .hit_count  (hit_count),
    .miss_count (miss_count),
    .evict_busy (evict_busy)
);

// File: tb/sim_wpc_cache.sv
// Bench for wpc_cache: directed policy and eviction cases, then seeded random traffic.
module sim_wpc_cache;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_policy = 2'd1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ack;
    logic [DW-1:0] req_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready = 1'b1;
    logic [DW-1:0] mem_rdata;
    logic [15:0]   hit_count, miss_count;

    logic [DW-1:0] mem_m  [NW];
    logic [DW-1:0] shadow [NW];
    logic [AW-1:0] lg_addr [256];
    bit            lg_we   [256];
    int            lg_n = 0;
    bit            rnd_ready = 1'b0;
    int            n_chk = 0;
    int            n_fail = 0;

    wpc_cache u0 (
        .clk(clk), .rst_n(rst_n), .cfg_policy(cfg_policy),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] minit(input int a);
        return DW'(a * 40503) ^ 16'h5A5A;
    endfunction

    // Main memory model with a beat log.
    assign mem_rdata = mem_m[mem_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem_m[i] <= minit(i);
        end else if (mem_req && mem_ready) begin
            if (mem_we) mem_m[mem_addr] <= mem_wdata;
            if (lg_n < 256) begin
                lg_addr[lg_n] <= mem_addr;
                lg_we[lg_n]   <= mem_we;
            end
            lg_n <= lg_n + 1;
        end
    end

    // Memory stall pattern, changed away from the active edge.
    always @(negedge clk) mem_ready <= rnd_ready ? (($urandom % 4) != 0) : 1'b1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < NW; i++) shadow[i] = minit(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One host request; returns read data, cycles to acknowledge and hit flag.
    task automatic host(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int cyc, output bit hit);
        int h0, m0;
        bit got;
        h0 = hit_count; m0 = miss_count;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        cyc = 0; got = 1'b0; rd = '0;
        while (!got && cyc < 1000) begin
            #1;
            if (req_ack) begin
                got = 1'b1;
                rd = req_rdata;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(got, "R9", "acknowledge", int'(got), 1);
        chk((hit_count - h0) + (miss_count - m0) == 1, "R11", "counter step",
            (hit_count - h0) + (miss_count - m0), 1);
        hit = (hit_count != h0);
        if (wr && got) shadow[a] = wd;
    endtask

    task automatic chk_log(input string req, input int base, input logic [AW-1:0] start,
                           input bit we, input int n);
        for (int i = 0; i < n; i++) begin
            chk(lg_addr[base+i] == start + AW'(i) && lg_we[base+i] == we, req, "beat addr",
                int'(lg_addr[base+i]), int'(start) + i);
        end
    endtask

    localparam logic [AW-1:0] A = 10'h010, B = 10'h050, C = 10'h090;
    localparam logic [AW-1:0] D = 10'h130, E = 10'h200, F = 10'h3F1;

    initial begin
        logic [DW-1:0] rd;
        int cyc, s;
        bit hit;
        void'($urandom(32'd20417));
        fork
            begin
                #(CLK_PERIOD * 150000);
                chk(1'b0, "R9", "watchdog", 0, 1);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none

        do_reset();
        @(negedge clk); #1;
        chk(!req_ack && !mem_req, "R7", "idle outputs", int'(req_ack), 0);
        chk(hit_count == 0 && miss_count == 0, "R7", "counters", int'(hit_count), 0);

        // Write-back policy
        cfg_policy = 2'd1;
        s = lg_n; host(0, A, 0, rd, cyc, hit);
        chk(!hit && rd == shadow[A], "R2", "read miss data", int'(rd), int'(shadow[A]));
        chk(cyc == 5 && lg_n - s == 4, "R2", "miss latency", cyc, 5);
        chk_log("R2", s, A, 0, 4);
        host(0, A + 2, 0, rd, cyc, hit);
        chk(hit && cyc == 0 && rd == shadow[A+2], "R1", "read hit", int'(rd), int'(shadow[A+2]));
        s = lg_n; host(1, A + 1, 16'hBEEF, rd, cyc, hit);
        chk(hit && cyc == 0 && lg_n == s, "R4", "write hit no beat", lg_n - s, 0);
        chk(mem_m[A+1] == minit(A + 1), "R4", "memory untouched", int'(mem_m[A+1]), int'(minit(A + 1)));
        host(0, A + 1, 0, rd, cyc, hit);
        chk(hit && rd == 16'hBEEF, "R4", "read own write", int'(rd), 16'hBEEF);
        host(0, B, 0, rd, cyc, hit);
        chk(!hit && cyc == 5, "R12", "second way fill", cyc, 5);
        host(0, A, 0, rd, cyc, hit);
        chk(hit, "R12", "both ways resident", int'(hit), 1);
        s = lg_n; host(0, C, 0, rd, cyc, hit);
        chk(!hit && cyc == 9 && rd == shadow[C], "R5", "copy-back latency", cyc, 9);
        chk_log("R5", s, A, 1, 4);
        chk_log("R5", s + 4, C, 0, 4);
        chk(mem_m[A+1] == 16'hBEEF, "R5", "written back", int'(mem_m[A+1]), 16'hBEEF);
        s = lg_n; host(0, A + 1, 0, rd, cyc, hit);
        chk(!hit && lg_n - s == 4 && rd == 16'hBEEF, "R12", "round-robin victim", lg_n - s, 4);
        host(0, C, 0, rd, cyc, hit);
        chk(hit, "R12", "recent fill kept", int'(hit), 1);

        // Write-through policy
        cfg_policy = 2'd0;
        s = lg_n; host(1, A + 3, 16'h1234, rd, cyc, hit);
        chk(hit && cyc == 1 && lg_n - s == 1, "R3", "write hit beat", cyc, 1);
        chk(mem_m[A+3] == 16'h1234, "R3", "memory written", int'(mem_m[A+3]), 16'h1234);
        host(0, A + 3, 0, rd, cyc, hit);
        chk(hit && rd == 16'h1234, "R3", "cache updated", int'(rd), 16'h1234);
        host(1, D, 16'hCAFE, rd, cyc, hit);
        chk(!hit && cyc == 1, "R3", "write miss", cyc, 1);
        host(0, D, 0, rd, cyc, hit);
        chk(!hit && rd == 16'hCAFE, "R3", "no allocate", int'(hit), 0);

        // Write-around policy
        cfg_policy = 2'd2;
        host(1, A, 16'h7777, rd, cyc, hit);
        chk(hit && cyc == 1, "R6", "clean hit write", cyc, 1);
        host(0, A, 0, rd, cyc, hit);
        chk(!hit && rd == 16'h7777, "R6", "line dropped", int'(hit), 0);
        cfg_policy = 2'd1;
        host(1, D + 1, 16'hBEEF, rd, cyc, hit);
        cfg_policy = 2'd2;
        s = lg_n; host(1, D + 2, 16'h4321, rd, cyc, hit);
        chk(hit && cyc == 5 && lg_n - s == 5, "R6", "dirty hit copy-back", cyc, 5);
        chk_log("R6", s, D, 1, 4);
        chk_log("R6", s + 4, D + 2, 1, 1);
        chk(mem_m[D+1] == 16'hBEEF && mem_m[D+2] == 16'h4321, "R6", "memory content",
            int'(mem_m[D+1]), 16'hBEEF);
        host(0, D + 1, 0, rd, cyc, hit);
        chk(!hit && rd == 16'hBEEF, "R6", "read after drop", int'(rd), 16'hBEEF);
        host(1, E, 16'h5555, rd, cyc, hit);
        chk(!hit && cyc == 1, "R6", "write miss", cyc, 1);
        host(0, E, 0, rd, cyc, hit);
        chk(!hit && rd == 16'h5555, "R6", "no allocate", int'(hit), 0);

        // Write-back write miss allocates
        cfg_policy = 2'd1;
        s = lg_n; host(1, F, 16'h9999, rd, cyc, hit);
        chk(!hit && cyc == 5 && lg_n - s == 4, "R4", "allocating write miss", cyc, 5);
        host(0, F, 0, rd, cyc, hit);
        chk(hit && rd == 16'h9999, "R4", "allocated line", int'(rd), 16'h9999);
        chk(mem_m[F] == minit(F), "R4", "memory untouched", int'(mem_m[F]), int'(minit(F)));

        // Reset clears lines and counters
        do_reset();
        @(negedge clk); #1;
        chk(hit_count == 0 && miss_count == 0, "R7", "counters after reset", int'(miss_count), 0);
        host(0, A, 0, rd, cyc, hit);
        chk(!hit && rd == shadow[A], "R7", "first read misses", int'(hit), 0);

        // Seeded random traffic with stalls and policy changes
        rnd_ready = 1'b1;
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            bit wr;
            logic [DW-1:0] wd;
            if (i % 60 == 0) cfg_policy = 2'($urandom % 3);
            a  = AW'((($urandom % 6) << 4) | ($urandom % 16));
            wr = 1'($urandom % 2);
            wd = DW'($urandom);
            host(wr, a, wd, rd, cyc, hit);
            if (!wr) chk(rd == shadow[a], "R10", "random read", int'(rd), int'(shadow[a]));
        end
        rnd_ready = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule